// File: doc/BRIEF.md
# OLED Panel Bring-up and Power Sequencer

This block brings a monochrome OLED panel controller out of reset and then keeps it serviced. Right after reset it streams a fixed configuration script to the controller as command bytes, all under one chip-select period, while the panel supply enable stays off. It then idles for a timed settle interval derived from the clock frequency. Next it blanks the whole visible area: for every page it positions the controller's write pointer with three command bytes and streams a row of zero data bytes.

Once the clear is complete the block accepts runtime requests of two kinds. A power request selects off, dim or normal, and each level maps to its own opcodes plus the supply-enable pin. A contrast request sends the contrast opcode followed by the value. Requests can arrive at any time. Those that arrive before the clear ends wait in a small queue, and all requests are served strictly in arrival order. Bytes leave through a valid/ready byte interface to an external SPI shifter, with a command/data flag and a chip-select level. The last applied power level and contrast can be read on dedicated outputs.

Top module: `oled_seq_top`

## Requirements
- R1: While reset is held and right after it is released, `panel_pwr_en` is 0, `pwr_level` reads 0, `contrast` reads 0x32, `init_done` is 0 and `busy` is 1.
- R2: After reset the block sends 34 command bytes (`tx_cmd`=1) in one continuous `spi_sel` period, in this exact order: 02 12 40 2E 81 32 82 80 A1 A6 A8 3F D3 40 AD 8E C8 D5 F0 D8 05 D9 F1 DA 12 DB 3C 91 3F 3F 3F 3F AF A4 (hex).
- R3: While `tx_valid` is 1 and `tx_ready` is 0, `tx_valid`, `tx_byte` and `tx_cmd` keep their values into the next cycle. A byte is transferred only on a cycle where both are 1.
- R4: Between the last script byte and the first clear byte, `spi_sel` stays 0 for exactly (CLK_HZ/1000)*WAIT_MS cycles.
- R5: The clear is one `spi_sel` period holding PAGES groups. Group p is the command bytes 0xB0+p, 0x00+(COL_OFS mod 16) and 0x10+(COL_OFS div 16), followed by COLS bytes of 0x00 with `tx_cmd`=0. When it ends, `init_done` rises and stays at 1.
- R6: A power request (`req_kind`=0) with argument 0 sends the single command byte 0xAE and then clears `panel_pwr_en` and `pwr_level`.
- R7: A power request with argument 1 sends 0xAC then 0xA4 and then sets `panel_pwr_en`=1 and `pwr_level`=1.
- R8: A power request with argument 2 or more sends 0xAF then 0xA4 and then sets `panel_pwr_en`=1 and `pwr_level`=2.
- R9: A contrast request (`req_kind`=1) sends the command bytes 0x81 and then the argument, after which `contrast` reads the argument.
- R10: Requests taken while the script, wait or clear is running are held and served after the clear, in the order they were taken. `req_ready` is 0 while QDEPTH requests are waiting.
- R11: Each request is sent in its own `spi_sel` period, and `spi_sel` drops only after a byte transfer. `busy` is 0 only when the block is idle and no request is waiting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_kind | input | 1 | 0 = power level, 1 = contrast |
| req_arg | input | 8 | Power level or contrast value |
| req_ready | output | 1 | Request queue has space |
| tx_valid | output | 1 | Byte offered to the shifter |
| tx_byte | output | 8 | Byte to shift out |
| tx_cmd | output | 1 | 1 = command byte, 0 = display data byte |
| tx_ready | input | 1 | Shifter takes the byte |
| spi_sel | output | 1 | Chip-select level, 1 = selected |
| panel_pwr_en | output | 1 | Panel supply enable |
| pwr_level | output | 2 | Last applied power level (0, 1 or 2) |
| contrast | output | 8 | Last applied contrast |
| init_done | output | 1 | Script, wait and clear finished |
| busy | output | 1 | Sequencing or requests pending |

## Verification
The hardest state to reach is a backlog of requests that builds up while the start-up sequence is still running. That backlog fills the queue, drops `req_ready`, and must then drain in order once the clear finishes. The stimulus pushes four mixed requests in the first cycles after reset. It then checks that `req_ready` is low and that the first four post-clear select periods match the push order. The shifter's ready line toggles at random for the whole run, so every byte of the script, the clear and the requests also crosses stalled handshakes. A random mix of power levels (including 0, 1 and arguments far above 2) and contrast values follows.

// File: rtl/oled_seq_pkg.sv
package oled_seq_pkg;

  localparam logic [7:0] OP_COL_LO    = 8'h00;
  localparam logic [7:0] OP_COL_HI    = 8'h10;
  localparam logic [7:0] OP_PAGE      = 8'hB0;
  localparam logic [7:0] OP_CONTRAST  = 8'h81;
  localparam logic [7:0] OP_DISP_OFF  = 8'hAE;
  localparam logic [7:0] OP_DISP_DIM  = 8'hAC;
  localparam logic [7:0] OP_DISP_ON   = 8'hAF;
  localparam logic [7:0] OP_SHOW_RAM  = 8'hA4;
  localparam logic [7:0] CONTRAST_RST = 8'h32;

  localparam int SCRIPT_LEN = 34;

  typedef struct packed {
    logic       is_data;
    logic [7:0] val;
  } script_ent_t;

  typedef enum logic [2:0] {
    ST_SCRIPT, ST_WAIT, ST_CLR_POS, ST_CLR_FILL, ST_IDLE, ST_REQ
  } seq_st_t;

  typedef enum logic {RQ_POWER = 1'b0, RQ_CONTRAST = 1'b1} req_kind_t;

  typedef struct packed {
    req_kind_t  kind;
    logic [7:0] arg;
  } req_t;

  function automatic script_ent_t cmd_ent(input logic [7:0] v);
    cmd_ent = '{is_data: 1'b0, val: v};
  endfunction

  // Bring-up script; every entry goes out in command mode.
  function automatic script_ent_t script_at(input int i);
    case (i)
      0:  script_at = cmd_ent(8'h02);  // column low nibble 2
      1:  script_at = cmd_ent(8'h12);  // column high nibble 2
      2:  script_at = cmd_ent(8'h40);  // start line 0
      3:  script_at = cmd_ent(8'h2E);  // scrolling halted
      4:  script_at = cmd_ent(8'h81);  // contrast opcode
      5:  script_at = cmd_ent(8'h32);
      6:  script_at = cmd_ent(8'h82);  // bank brightness opcode
      7:  script_at = cmd_ent(8'h80);
      8:  script_at = cmd_ent(8'hA1);  // segment remap
      9:  script_at = cmd_ent(8'hA6);  // non-inverted
      10: script_at = cmd_ent(8'hA8);  // mux ratio opcode
      11: script_at = cmd_ent(8'h3F);
      12: script_at = cmd_ent(8'hD3);  // vertical offset opcode
      13: script_at = cmd_ent(8'h40);
      14: script_at = cmd_ent(8'hAD);  // supply config opcode
      15: script_at = cmd_ent(8'h8E);  // external supply
      16: script_at = cmd_ent(8'hC8);  // reversed common scan
      17: script_at = cmd_ent(8'hD5);  // clock opcode
      18: script_at = cmd_ent(8'hF0);  // freq 15, divide 0
      19: script_at = cmd_ent(8'hD8);  // colour/power mode opcode
      20: script_at = cmd_ent(8'h05);  // mono, low power
      21: script_at = cmd_ent(8'hD9);  // precharge opcode
      22: script_at = cmd_ent(8'hF1);  // phase2 15, phase1 1
      23: script_at = cmd_ent(8'hDA);  // common pin layout opcode
      24: script_at = cmd_ent(8'h12);  // alternative layout
      25: script_at = cmd_ent(8'hDB);  // deselect level opcode
      26: script_at = cmd_ent(8'h3C);
      27: script_at = cmd_ent(8'h91);  // lookup table opcode
      28: script_at = cmd_ent(8'h3F);
      29: script_at = cmd_ent(8'h3F);
      30: script_at = cmd_ent(8'h3F);
      31: script_at = cmd_ent(8'h3F);
      32: script_at = cmd_ent(8'hAF);  // display on, normal
      default: script_at = cmd_ent(8'hA4);  // show RAM contents
    endcase
  endfunction

endpackage

// File: rtl/oled_req_fifo.sv
module oled_req_fifo #(
  parameter int DEPTH = 4,   // power of two
  parameter int W     = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   cnt;

  assign empty = (cnt == '0);
  assign full  = (cnt == (AW+1)'(DEPTH));
  assign dout  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R10
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);

endmodule

// File: rtl/oled_delay.sv
module oled_delay #(
  parameter int CYCLES = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt;

  assign expired = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/oled_seq_fsm.sv
module oled_seq_fsm
  import oled_seq_pkg::*;
#(
  parameter int PAGES   = 8,
  parameter int COLS    = 96,
  parameter int COL_OFS = 18
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tx_ready,
  input  logic       wait_expired,
  input  logic       q_empty,
  input  req_t       q_head,
  output logic       wait_run,
  output logic       q_pop,
  output logic       tx_valid,
  output logic [7:0] tx_byte,
  output logic       tx_cmd,
  output logic       spi_sel,
  output logic       panel_pwr_en,
  output logic [1:0] pwr_level,
  output logic [7:0] contrast,
  output logic       init_done,
  output logic       idle
);
  localparam int IW = $clog2(SCRIPT_LEN);
  localparam int PW = (PAGES > 1) ? $clog2(PAGES) : 1;
  localparam int CW = (COLS > 1) ? $clog2(COLS) : 1;
  localparam logic [IW-1:0] IDX_LAST  = IW'(SCRIPT_LEN - 1);
  localparam logic [PW-1:0] PAGE_LAST = PW'(PAGES - 1);
  localparam logic [CW-1:0] COL_LAST  = CW'(COLS - 1);
  localparam logic [7:0] COL_LO_B = OP_COL_LO | 8'(COL_OFS % 16);
  localparam logic [7:0] COL_HI_B = OP_COL_HI | 8'(COL_OFS / 16);

  seq_st_t       st;
  logic [IW-1:0] idx;
  logic [PW-1:0] page;
  logic [1:0]    pos;
  logic [CW-1:0] col;
  req_t          cur;
  logic          rsub;
  script_ent_t   ent;
  logic          hs;
  logic          req_last;

  assign ent      = script_at(int'(idx));
  assign hs       = tx_valid && tx_ready;
  assign wait_run = (st == ST_WAIT);
  assign idle     = (st == ST_IDLE);
  assign q_pop    = (st == ST_IDLE) && !q_empty;
  assign spi_sel  = tx_valid;
  assign req_last = (cur.kind == RQ_CONTRAST) ? rsub : ((cur.arg == 8'd0) || rsub);

  // Byte decode from registered state only; no input reaches the byte lane.
  always_comb begin
    tx_valid = 1'b0;
    tx_byte  = 8'h00;
    tx_cmd   = 1'b1;
    case (st)
      ST_SCRIPT: begin
        tx_valid = 1'b1;
        tx_byte  = ent.val;
        tx_cmd   = !ent.is_data;
      end
      ST_CLR_POS: begin
        tx_valid = 1'b1;
        case (pos)
          2'd0:    tx_byte = OP_PAGE | 8'(page);
          2'd1:    tx_byte = COL_LO_B;
          default: tx_byte = COL_HI_B;
        endcase
      end
      ST_CLR_FILL: begin
        tx_valid = 1'b1;
        tx_cmd   = 1'b0;
      end
      ST_REQ: begin
        tx_valid = 1'b1;
        if (cur.kind == RQ_CONTRAST)  tx_byte = rsub ? cur.arg : OP_CONTRAST;
        else if (cur.arg == 8'd0)     tx_byte = OP_DISP_OFF;
        else if (rsub)                tx_byte = OP_SHOW_RAM;
        else if (cur.arg == 8'd1)     tx_byte = OP_DISP_DIM;
        else                          tx_byte = OP_DISP_ON;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= ST_SCRIPT;
      idx          <= '0;
      page         <= '0;
      pos          <= '0;
      col          <= '0;
      cur          <= '0;
      rsub         <= 1'b0;
      panel_pwr_en <= 1'b0;
      pwr_level    <= 2'd0;
      contrast     <= CONTRAST_RST;
      init_done    <= 1'b0;
    end else begin
      case (st)
        ST_SCRIPT: if (hs) begin
          if (idx == IDX_LAST) st <= ST_WAIT;
          else                 idx <= idx + 1'b1;
        end
        ST_WAIT: if (wait_expired) begin
          st   <= ST_CLR_POS;
          page <= '0;
          pos  <= '0;
        end
        ST_CLR_POS: if (hs) begin
          if (pos == 2'd2) begin
            pos <= '0;
            col <= '0;
            st  <= ST_CLR_FILL;
          end else begin
            pos <= pos + 1'b1;
          end
        end
        ST_CLR_FILL: if (hs) begin
          if (col == COL_LAST) begin
            col <= '0;
            if (page == PAGE_LAST) begin
              st        <= ST_IDLE;
              init_done <= 1'b1;
            end else begin
              page <= page + 1'b1;
              st   <= ST_CLR_POS;
            end
          end else begin
            col <= col + 1'b1;
          end
        end
        ST_IDLE: if (!q_empty) begin
          cur  <= q_head;
          rsub <= 1'b0;
          st   <= ST_REQ;
        end
        ST_REQ: if (hs) begin
          if (req_last) begin
            st <= ST_IDLE;
            if (cur.kind == RQ_CONTRAST) begin
              contrast <= cur.arg;
            end else begin
              panel_pwr_en <= (cur.arg != 8'd0);
              pwr_level    <= (cur.arg == 8'd0) ? 2'd0 :
                              (cur.arg == 8'd1) ? 2'd1 : 2'd2;
            end
          end else begin
            rsub <= 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R3
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte) && $stable(tx_cmd)));

  // R1
  pwr_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !init_done |-> !panel_pwr_en);

  // R11
  sel_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(spi_sel) |-> $past(tx_valid && tx_ready));

  // R4
  wait_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    wait_expired |-> !spi_sel);

endmodule

// File: rtl/oled_seq_top.sv
module oled_seq_top
  import oled_seq_pkg::*;
#(
  parameter int CLK_HZ  = 50_000_000,
  parameter int WAIT_MS = 100,
  parameter int PAGES   = 8,
  parameter int COLS    = 96,
  parameter int COL_OFS = 18,
  parameter int QDEPTH  = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  logic       req_kind,
  input  logic [7:0] req_arg,
  output logic       req_ready,
  output logic       tx_valid,
  output logic [7:0] tx_byte,
  output logic       tx_cmd,
  input  logic       tx_ready,
  output logic       spi_sel,
  output logic       panel_pwr_en,
  output logic [1:0] pwr_level,
  output logic [7:0] contrast,
  output logic       init_done,
  output logic       busy
);
  localparam int WAIT_CYC = (CLK_HZ / 1000) * WAIT_MS;
  localparam int REQ_W    = $bits(req_t);

  logic             q_full, q_empty, q_push, q_pop;
  logic [REQ_W-1:0] q_dout;
  logic             wait_run, wait_expired, fsm_idle;
  req_t             q_head;

  assign q_push    = req_valid && !q_full;
  assign req_ready = !q_full;
  assign q_head    = req_t'(q_dout);
  assign busy      = !fsm_idle || !q_empty;

  oled_req_fifo #(.DEPTH(QDEPTH), .W(REQ_W)) u_fifo (
    .clk(clk), .rst(rst), .push(q_push), .din({req_kind, req_arg}),
    .pop(q_pop), .dout(q_dout), .empty(q_empty), .full(q_full)
  );

  oled_delay #(.CYCLES(WAIT_CYC)) u_delay (
    .clk(clk), .rst(rst), .run(wait_run), .expired(wait_expired)
  );

  oled_seq_fsm #(.PAGES(PAGES), .COLS(COLS), .COL_OFS(COL_OFS)) u_fsm (
    .clk(clk), .rst(rst), .tx_ready(tx_ready), .wait_expired(wait_expired),
    .q_empty(q_empty), .q_head(q_head), .wait_run(wait_run), .q_pop(q_pop),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_cmd(tx_cmd), .spi_sel(spi_sel),
    .panel_pwr_en(panel_pwr_en), .pwr_level(pwr_level), .contrast(contrast),
    .init_done(init_done), .idle(fsm_idle)
  );

  // R10
  full_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> !$past(q_push));

endmodule

// File: tb/sim_oled_seq_top.sv
module sim_oled_seq_top;
  localparam int CLK_HZ = 10_000;
  localparam int WAIT_C = (CLK_HZ / 1000) * 100;
  localparam int PAGES  = 8;
  localparam int COLS   = 96;
  localparam int QD     = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_kind = 1'b0;
  logic [7:0] req_arg = 8'h00;
  logic tx_ready = 1'b0;
  logic req_ready, tx_valid, tx_cmd, spi_sel, panel_pwr_en, init_done, busy;
  logic [7:0] tx_byte, contrast;
  logic [1:0] pwr_level;

  int total = 0, bad = 0;
  logic [7:0] logb [4096];
  logic       logc [4096];
  int logn = 0, grp = 0, lowcnt = 0, hold_bad = 0;
  int gstart [64];
  logic prev_v = 1'b0, prev_r = 1'b0, prev_c = 1'b0, prev_sel = 1'b0;
  logic [7:0] prev_b = 8'h00;
  int exp_grp = 0;
  logic [1:0] m_lvl;
  logic       m_pwr;
  logic [7:0] m_con;

  always #10 clk = ~clk;

  oled_seq_top #(.CLK_HZ(CLK_HZ), .QDEPTH(QD)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_arg(req_arg), .req_ready(req_ready), .tx_valid(tx_valid),
    .tx_byte(tx_byte), .tx_cmd(tx_cmd), .tx_ready(tx_ready), .spi_sel(spi_sel),
    .panel_pwr_en(panel_pwr_en), .pwr_level(pwr_level), .contrast(contrast),
    .init_done(init_done), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] script_exp(input int i);
    logic [7:0] t [34] = '{8'h02, 8'h12, 8'h40, 8'h2E, 8'h81, 8'h32, 8'h82, 8'h80,
                           8'hA1, 8'hA6, 8'hA8, 8'h3F, 8'hD3, 8'h40, 8'hAD, 8'h8E,
                           8'hC8, 8'hD5, 8'hF0, 8'hD8, 8'h05, 8'hD9, 8'hF1, 8'hDA,
                           8'h12, 8'hDB, 8'h3C, 8'h91, 8'h3F, 8'h3F, 8'h3F, 8'h3F,
                           8'hAF, 8'hA4};
    return t[i];
  endfunction

  // Shifter model and byte logger; ready changes before sampling.
  always @(negedge clk) begin
    tx_ready = ($urandom % 4) != 0;
    if (!rst) begin
      if (prev_v && !prev_r)
        if (!(tx_valid && tx_byte == prev_b && tx_cmd == prev_c)) hold_bad++;
      if (spi_sel && !prev_sel && grp < 63) begin
        grp++;
        gstart[grp] = logn;
      end
      if (!spi_sel && grp == 1) lowcnt++;
      if (tx_valid && tx_ready && logn < 4096) begin
        logb[logn] = tx_byte;
        logc[logn] = tx_cmd;
        logn++;
      end
      prev_v = tx_valid; prev_r = tx_ready; prev_b = tx_byte;
      prev_c = tx_cmd;   prev_sel = spi_sel;
    end
  end

  task automatic send_req(input logic k, input logic [7:0] a);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_arg = a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  function automatic int glen(input int g);
    return (g == grp) ? (logn - gstart[g]) : (gstart[g+1] - gstart[g]);
  endfunction

  task automatic check_group(input int g, input logic k, input logic [7:0] a);
    logic [7:0] eb [2];
    int elen;
    string tag;
    if (k) begin
      eb[0] = 8'h81; eb[1] = a; elen = 2; tag = "R9";
    end else if (a == 0) begin
      eb[0] = 8'hAE; eb[1] = 8'h00; elen = 1; tag = "R6";
    end else if (a == 1) begin
      eb[0] = 8'hAC; eb[1] = 8'hA4; elen = 2; tag = "R7";
    end else begin
      eb[0] = 8'hAF; eb[1] = 8'hA4; elen = 2; tag = "R8";
    end
    chk(glen(g) == elen, {tag, " length"}, glen(g), elen);
    for (int i = 0; i < elen && i < glen(g); i++) begin
      chk(logb[gstart[g]+i] == eb[i], {tag, " byte"}, int'(logb[gstart[g]+i]), int'(eb[i]));
      chk(logc[gstart[g]+i] == 1'b1, {tag, " cmd flag"}, int'(logc[gstart[g]+i]), 1);
    end
    if (k) m_con = a;
    else begin
      m_pwr = (a != 0);
      m_lvl = (a == 0) ? 2'd0 : (a == 1) ? 2'd1 : 2'd2;
    end
  endtask

  task automatic check_state(input string tag);
    chk(contrast == m_con, {tag, " R9 contrast"}, int'(contrast), int'(m_con));
    chk(pwr_level == m_lvl, {tag, " R6 R7 R8 level"}, int'(pwr_level), int'(m_lvl));
    chk(panel_pwr_en == m_pwr, {tag, " R6 R7 R8 supply"}, int'(panel_pwr_en), int'(m_pwr));
  endtask

  task automatic run_req(input logic k, input logic [7:0] a);
    send_req(k, a);
    do @(negedge clk); while (busy);
    exp_grp++;
    chk(grp == exp_grp, "R11 own select period", grp, exp_grp);
    check_group(grp, k, a);
    check_state("post-request");
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [7:0] ex;
    int k0, base;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    // R1: values while reset is applied
    chk(panel_pwr_en == 0, "R1 supply", int'(panel_pwr_en), 0);
    chk(pwr_level == 0, "R1 level", int'(pwr_level), 0);
    chk(contrast == 8'h32, "R1 contrast", int'(contrast), 8'h32);
    chk(init_done == 0, "R1 init_done", int'(init_done), 0);
    chk(busy == 1, "R1 busy", int'(busy), 1);
    rst = 1'b0;

    // R10: backlog during start-up
    send_req(1'b1, 8'h5A);
    send_req(1'b0, 8'h01);
    send_req(1'b0, 8'h03);
    send_req(1'b1, 8'h07);
    chk(req_ready == 0, "R10 queue full ready", int'(req_ready), 0);
    chk(init_done == 0, "R10 still starting", int'(init_done), 0);

    while (!init_done) @(negedge clk);
    m_con = 8'h32; m_lvl = 2'd0; m_pwr = 1'b0;

    // R2: script
    chk(glen(1) == 34, "R2 script length", glen(1), 34);
    for (int i = 0; i < 34; i++) begin
      chk(logb[gstart[1]+i] == script_exp(i), "R2 script byte",
          int'(logb[gstart[1]+i]), int'(script_exp(i)));
      chk(logc[gstart[1]+i] == 1'b1, "R2 command flag", int'(logc[gstart[1]+i]), 1);
    end
    // R4: settle interval
    chk(lowcnt == WAIT_C, "R4 quiet cycles", lowcnt, WAIT_C);
    // R5: clear burst
    chk(glen(2) == PAGES * (COLS + 3), "R5 clear length", glen(2), PAGES * (COLS + 3));
    for (int p = 0; p < PAGES; p++) begin
      base = gstart[2] + p * (COLS + 3);
      ex = 8'hB0 + 8'(p);
      chk(logb[base] == ex && logc[base], "R5 page byte", int'(logb[base]), int'(ex));
      chk(logb[base+1] == 8'h02 && logc[base+1], "R5 column low", int'(logb[base+1]), 8'h02);
      chk(logb[base+2] == 8'h11 && logc[base+2], "R5 column high", int'(logb[base+2]), 8'h11);
      k0 = 0;
      for (int c = 0; c < COLS; c++)
        if (logb[base+3+c] != 8'h00 || logc[base+3+c] != 1'b0) k0++;
      chk(k0 == 0, "R5 zero data bytes", k0, 0);
    end

    // R10: drain order after clear
    do @(negedge clk); while (busy);
    chk(grp == 6, "R10 R11 queued periods", grp, 6);
    check_group(3, 1'b1, 8'h5A);
    check_group(4, 1'b0, 8'h01);
    check_group(5, 1'b0, 8'h03);
    check_group(6, 1'b1, 8'h07);
    check_state("R10 drained");
    chk(init_done == 1, "R5 init_done sticky", int'(init_done), 1);
    chk(busy == 0, "R11 idle busy", int'(busy), 0);
    exp_grp = 6;

    // Directed corners
    run_req(1'b0, 8'h00);   // R6
    run_req(1'b0, 8'h00);   // R6 repeated off
    run_req(1'b0, 8'h01);   // R7 from off
    run_req(1'b0, 8'h02);   // R8 exact
    run_req(1'b0, 8'hFF);   // R8 far above
    run_req(1'b1, 8'h00);   // R9 lowest
    run_req(1'b1, 8'hFF);   // R9 highest

    // Random mix
    for (int n = 0; n < 20; n++) begin
      int sel;
      sel = $urandom % 6;
      if (sel < 2) run_req(1'b1, 8'($urandom));
      else if (sel == 2) run_req(1'b0, 8'h00);
      else if (sel == 3) run_req(1'b0, 8'h01);
      else run_req(1'b0, 8'(2 + ($urandom % 254)));
    end

    // R3: stall hold observed throughout
    chk(hold_bad == 0, "R3 stalled byte held", hold_bad, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule